// File: doc/BRIEF.md
# Byte-Wide Accumulator Processor Core

This block is a very small processor that runs programs out of a synchronous byte memory. It has a 16-bit address space and an 8-bit data path. A start pulse loads a program address. The core then fetches one-byte opcodes, decodes them and executes them strictly one after another. It has four 8-bit registers, of which the instruction set writes only the first (the accumulator, A). It also has a 16-bit program counter, a byte adder with a carry flag, and a halted state.

Three opcodes exist. 8'hB0 copies the next byte into A. 8'h04 adds the next byte into A. 8'hF4 stops the core. Any other opcode value also stops the core and raises an illegal-opcode flag. The byte that follows a load or add opcode is always consumed as data. The memory returns the byte one cycle after the address and read strobe are presented.

Top module: `acc_core`

## Requirements
- R1: After reset, A, carry and the illegal flag are 0, halted is 0, and the core issues no reads until start is pulsed.
- R2: A start pulse, taken while the core is idle or halted, loads start_addr into the program counter. In the next cycle the core reads that address.
- R3: Opcode 8'hB0 writes the following byte into A. The next opcode is then fetched two addresses later.
- R4: Opcode 8'h04 sets A to (A + byte) mod 256 and sets carry to the carry-out of that sum. A load leaves carry unchanged.
- R5: The byte after 8'hB0 or 8'h04 is never decoded, even when it equals a defined opcode.
- R6: Opcode 8'hF4 sets halted. While halted, mem_rd stays 0 and mem_addr holds the address of the halt opcode.
- R7: Any opcode other than 8'hB0, 8'h04 or 8'hF4 halts the core, sets illegal_op, and leaves A unchanged.
- R8: Each load or add takes 4 cycles: an opcode read at the PC, a decode cycle, an operand read at PC+1, and an execute cycle. Each read strobe lasts exactly one cycle. A program of n load/add instructions followed by a halt raises halted 4n+3 cycles after start is taken, after 2n+1 reads.
- R9: The program counter wraps from 16'hFFFF to 16'h0000.
- R10: A start pulse while halted restarts the core and clears illegal_op. A and carry are kept.
- R11: A start pulse while a program is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins execution |
| start_addr | input | 16 | Address of the first opcode |
| mem_addr | output | 16 | Memory read address |
| mem_rd | output | 1 | Read strobe; data returns on the next cycle |
| mem_rdata | input | 8 | Byte returned by the memory |
| halted | output | 1 | Core is stopped |
| illegal_op | output | 1 | Core stopped on an undefined opcode |
| carry | output | 1 | Carry-out of the last add |
| reg_a | output | 8 | Current value of the accumulator |

## Verification
A wrong state transition shows up at the ports within one cycle. It appears as a read strobe lasting two cycles, a read during halt, or an address that does not step by exactly two after an execute cycle. A wrongly captured opcode class or a wrongly computed sum appears only in reg_a and carry once the program halts. Misreading an operand as an opcode shifts every later fetch address and changes the halt cycle count. So the directed programs compare the final accumulator, the flags, the halt address, the cycle count and the read count. The scenarios include operands whose values equal defined opcodes, a sum that overflows, a start pulse during a run, and a program that crosses the top of the address space.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CODE_LOAD = 8'hB0;
  localparam logic [BYTE_W-1:0] CODE_ADD  = 8'h04;
  localparam logic [BYTE_W-1:0] CODE_STOP = 8'hF4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_OPND,
    ST_EXEC,
    ST_HALT
  } state_t;

  typedef enum logic [1:0] {
    K_LOAD,
    K_ADD,
    K_STOP,
    K_BAD
  } kind_t;

  function automatic kind_t classify(input logic [BYTE_W-1:0] code);
    kind_t k;
    case (code)
      CODE_LOAD: k = K_LOAD;
      CODE_ADD:  k = K_ADD;
      CODE_STOP: k = K_STOP;
      default:   k = K_BAD;
    endcase
    return k;
  endfunction

  // {carry, sum} of a byte add
  function automatic logic [BYTE_W:0] add_wide(input logic [BYTE_W-1:0] x,
                                               input logic [BYTE_W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction
endpackage

// File: rtl/acc_pc.sv
module acc_pc #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step2,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc <= '0;
    else if (load)  pc <= load_val;
    else if (step2) pc <= pc + STEP;
  end
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
  parameter int NREGS  = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] widx,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [$clog2(NREGS)-1:0] ridx,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 regs[g] <= '0;
      else if (we && widx == ($clog2(NREGS))'(g)) regs[g] <= wdata;
    end
  end

  assign rdata = regs[ridx];
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] rdata,
  output state_t            state,
  output kind_t             kind,
  output logic              take_start,
  output logic              exec_fire,
  output logic              illegal_op
);
  state_t nxt;
  kind_t  dec_kind;

  assign dec_kind   = classify(rdata);
  assign take_start = start && (state == ST_IDLE || state == ST_HALT);
  assign exec_fire  = (state == ST_EXEC);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (start) nxt = ST_FETCH;
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: nxt = (dec_kind == K_LOAD || dec_kind == K_ADD) ? ST_OPND : ST_HALT;
      ST_OPND:   nxt = ST_EXEC;
      ST_EXEC:   nxt = ST_FETCH;
      ST_HALT:   if (start) nxt = ST_FETCH;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      kind       <= K_STOP;
      illegal_op <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_DECODE) kind <= dec_kind;
      if (take_start)
        illegal_op <= 1'b0;
      else if (state == ST_DECODE && dec_kind == K_BAD)
        illegal_op <= 1'b1;
    end
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NREGS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              halted,
  output logic              illegal_op,
  output logic              carry,
  output logic [BYTE_W-1:0] reg_a
);
  localparam int IDX_W = $clog2(NREGS);
  localparam logic [IDX_W-1:0] IDX_A = '0;

  state_t            state;
  kind_t             kind;
  logic              take_start;
  logic              exec_fire;
  logic [ADDR_W-1:0] pc;
  logic [BYTE_W:0]   sum_w;
  logic [BYTE_W-1:0] wr_val;

  acc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rdata      (mem_rdata),
    .state      (state),
    .kind       (kind),
    .take_start (take_start),
    .exec_fire  (exec_fire),
    .illegal_op (illegal_op)
  );

  acc_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take_start),
    .load_val (start_addr),
    .step2    (exec_fire),
    .pc       (pc)
  );

  assign sum_w  = add_wide(reg_a, mem_rdata);
  assign wr_val = (kind == K_LOAD) ? mem_rdata : sum_w[BYTE_W-1:0];

  acc_regfile #(.NREGS(NREGS), .DATA_W(BYTE_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (exec_fire),
    .widx  (IDX_A),
    .wdata (wr_val),
    .ridx  (IDX_A),
    .rdata (reg_a)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          carry <= 1'b0;
    else if (exec_fire && kind == K_ADD) carry <= sum_w[BYTE_W];
  end

  assign mem_rd   = (state == ST_FETCH) || (state == ST_OPND);
  assign mem_addr = (state == ST_OPND) ? pc + ADDR_W'(1) : pc;
  assign halted   = (state == ST_HALT);
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              halted,
  input logic              illegal_op,
  input logic              take_start,
  input logic              exec_fire
);
  a_r8_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  a_r6_halt_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_rd);

  a_r6_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> (halted && $stable(mem_addr)));

  a_r2_first_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    take_start |=> (mem_rd && mem_addr == $past(start_addr)));

  a_r3_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
    exec_fire |=> (mem_rd && mem_addr == $past(mem_addr) + ADDR_W'(2)));

  a_r7_illegal_halted: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> halted);
endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .start_addr (start_addr),
  .mem_addr   (mem_addr),
  .mem_rd     (mem_rd),
  .halted     (halted),
  .illegal_op (illegal_op),
  .take_start (take_start),
  .exec_fire  (exec_fire)
);

// File: tb/test_acc_core.sv
`timescale 1ns/1ps
module test_acc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_addr = '0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata = '0;
  logic        halted, illegal_op, carry;
  logic [7:0]  reg_a;

  int total = 0;
  int fails = 0;
  logic [7:0] mem [1024];

  always #2.5 clk = ~clk;

  acc_core i_acc_core (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .halted(halted), .illegal_op(illegal_op), .carry(carry), .reg_a(reg_a)
  );

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] b);
    mem[a[9:0]] = b;
  endtask

  task automatic run_prog(input logic [15:0] sa, input int poke_at,
                          output int cyc, output int reads, output logic [15:0] first);
    @(negedge clk); start_addr = sa; start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 1; reads = mem_rd ? 1 : 0; first = mem_rd ? mem_addr : 16'hDEAD;
    while (!halted && cyc < 400) begin
      if (cyc == poke_at) begin start = 1'b1; start_addr = 16'h0300; end
      @(negedge clk); start = 1'b0; cyc++;
      if (mem_rd) reads++;
    end
  endtask

  task automatic t_reset();
    check(reg_a == 8'h00, "R1", "A after reset", reg_a, 0);
    check(!carry && !illegal_op && !halted, "R1", "flags after reset",
          {carry, illegal_op, halted}, 0);
    for (int i = 0; i < 5; i++) begin
      check(!mem_rd, "R1", "no read while idle", mem_rd, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_sum();
    int c, r; logic [15:0] f;
    put(16'h1400, 8'hB0); put(16'h1401, 8'h21); put(16'h1402, 8'h04);
    put(16'h1403, 8'h42); put(16'h1404, 8'h04); put(16'h1405, 8'h12);
    put(16'h1406, 8'hF4);
    run_prog(16'h1400, -1, c, r, f);
    check(f == 16'h1400, "R2", "first fetch address", f, 16'h1400);
    check(reg_a == 8'h75, "R3", "A after load and adds", reg_a, 8'h75);
    check(carry == 1'b0, "R4", "carry no overflow", carry, 0);
    check(c == 15, "R8", "cycles to halt", c, 15);
    check(r == 7, "R8", "read count", r, 7);
    for (int i = 0; i < 4; i++) begin
      check(halted && !mem_rd && mem_addr == 16'h1406, "R6", "halt holds",
            mem_addr, 16'h1406);
      @(negedge clk);
    end
  endtask

  task automatic t_operand();
    int c, r; logic [15:0] f;
    put(16'h1500, 8'hB0); put(16'h1501, 8'h04); put(16'h1502, 8'h04);
    put(16'h1503, 8'hF4); put(16'h1504, 8'hF4);
    run_prog(16'h1500, -1, c, r, f);
    check(reg_a == 8'hF8, "R5", "opcode-valued operands used as data", reg_a, 8'hF8);
    check(mem_addr == 16'h1504, "R5", "halt address", mem_addr, 16'h1504);
    check(c == 11, "R5", "cycles to halt", c, 11);
  endtask

  task automatic t_carry();
    int c, r; logic [15:0] f;
    put(16'h0200, 8'hB0); put(16'h0201, 8'hF0); put(16'h0202, 8'h04);
    put(16'h0203, 8'h20); put(16'h0204, 8'hF4);
    run_prog(16'h0200, -1, c, r, f);
    check(reg_a == 8'h10, "R4", "wrapped sum", reg_a, 8'h10);
    check(carry == 1'b1, "R4", "carry set on overflow", carry, 1);
    put(16'h0260, 8'hB0); put(16'h0261, 8'h55); put(16'h0262, 8'hF4);
    run_prog(16'h0260, -1, c, r, f);
    check(reg_a == 8'h55, "R3", "load after restart", reg_a, 8'h55);
    check(carry == 1'b1, "R4", "load keeps carry", carry, 1);
    put(16'h0240, 8'h04); put(16'h0241, 8'h01); put(16'h0242, 8'hF4);
    run_prog(16'h0240, -1, c, r, f);
    check(reg_a == 8'h56, "R10", "A kept across restart", reg_a, 8'h56);
    check(carry == 1'b0, "R4", "carry cleared by add", carry, 0);
  endtask

  task automatic t_illegal();
    int c, r; logic [15:0] f;
    put(16'h0300, 8'hB0); put(16'h0301, 8'h33); put(16'h0302, 8'h77);
    run_prog(16'h0300, -1, c, r, f);
    check(halted && illegal_op, "R7", "undefined opcode halts and flags",
          {halted, illegal_op}, 3);
    check(reg_a == 8'h33, "R7", "A unchanged", reg_a, 8'h33);
    check(mem_addr == 16'h0302, "R7", "halt address", mem_addr, 16'h0302);
    put(16'h0310, 8'hF4);
    run_prog(16'h0310, -1, c, r, f);
    check(!illegal_op && halted, "R10", "restart clears illegal flag",
          illegal_op, 0);
    check(c == 3, "R10", "restart fetches from new address", c, 3);
  endtask

  task automatic t_busy_start();
    int c, r; logic [15:0] f;
    put(16'h0380, 8'hB0); put(16'h0381, 8'h10); put(16'h0382, 8'h04);
    put(16'h0383, 8'h05); put(16'h0384, 8'hF4);
    run_prog(16'h0380, 2, c, r, f);
    check(reg_a == 8'h15, "R11", "start during run ignored", reg_a, 8'h15);
    check(c == 11 && !illegal_op, "R11", "cycle count unchanged", c, 11);
  endtask

  task automatic t_wrap();
    int c, r; logic [15:0] f;
    put(16'hFFFE, 8'hB0); put(16'hFFFF, 8'h9A); put(16'h0000, 8'hF4);
    run_prog(16'hFFFE, -1, c, r, f);
    check(reg_a == 8'h9A, "R9", "operand at top address", reg_a, 8'h9A);
    check(mem_addr == 16'h0000, "R9", "pc wrapped", mem_addr, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'hF4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sum();
    t_operand();
    t_carry();
    t_illegal();
    t_busy_start();
    t_wrap();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule